// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is one 8-bit general purpose I/O port, controlled through a small synchronous register bus. Three register locations hold the pin direction, the output data and the sampled pin levels. For each pin the block derives three pad controls: an output enable, an output value and a pull-up request. It also takes back the raw pad level through a two-stage synchronizer. The synchronizer is a level latch that is open while the clock is high and closed while it is low. A rising-edge flop follows the latch.

Each pin is always in one of four modes, selected by its {direction, data} bit pair:

| Mode | Pair | Pad behaviour |
|------|------|---------------|
| MODE_FLOAT | 00 | Undriven input |
| MODE_PULL | 01 | Input with pull-up, unless the global pull-up disable is high |
| MODE_DRIVE_LO | 10 | Drives 0 |
| MODE_DRIVE_HI | 11 | Drives 1 |

The mode changes on these transitions:

- **FLOAT↔PULL**: a write to the data register, or a toggle write.
- **DRIVE_LO↔DRIVE_HI**: a write to the data register, or a toggle write.
- **FLOAT↔DRIVE_LO** and **PULL↔DRIVE_HI**: a write to the direction register.

A pin crosses diagonally (FLOAT↔DRIVE_HI, PULL↔DRIVE_LO) only through one of the other two modes, because each bus write changes a single register.

Software reads the pin location to see the synchronized pad level. This works for output pins as well, which gives a loopback. Writing ones to the pin location inverts the selected output data bits, so any bit can be flipped in one write without a read-modify-write sequence.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction and data registers are 0, pad_oe and pad_pu are all 0, and rd_data is 0.
- R2: The address map is: data register at address 0, direction register at address 1, pin register at address 2. A write to address 0 or 1 stores wr_data, and a read returns that register on rd_data one clock after the address is presented.
- R3: A pin whose direction bit is 1 has pad_oe high and pad_out equal to its data bit. A pin whose direction bit is 0 has pad_oe low.
- R4: A pin with direction 0 and data 1 has pad_pu high while pu_off is low. A pin in any other mode has pad_pu low.
- R5: While pu_off is high, every pad_pu bit is 0, whatever the direction and data bits are.
- R6: A write to address 2 inverts each data bit whose wr_data bit is 1 and leaves the other data bits unchanged, whatever the direction bits are.
- R7: A write to address 2 does not change the value read back from address 2. That value keeps following the pads.
- R8: A pad change made while the clock is high is not yet visible in a read of address 2 registered at the next rising edge. It is visible in the read registered one edge later.
- R9: Address 2 returns the synchronized pad level for pins configured as outputs too.
- R10: Address 3 is unmapped. A write to it changes no register, and a read of it returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the latch is open while clk is high |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the address of the previous cycle |
| pu_off | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up request |

## Verification
A wrong direction or data bit shows on pad_oe, pad_out or pad_pu in the cycle right after the write that caused it. It shows on rd_data one cycle later, when that register is read. A wrong toggle shows as a data bit that flipped when it should have held, or held when it should have flipped. A synchronizer with an extra or a missing stage moves the visible pad change by one read cycle, and the bench checks both sides of the expected edge. A pin register that wrongly accepts writes returns the written value instead of the pad level on the next read.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    // encoding is {direction, data}
    typedef enum logic [1:0] {
        MODE_FLOAT    = 2'b00,
        MODE_PULL     = 2'b01,
        MODE_DRIVE_LO = 2'b10,
        MODE_DRIVE_HI = 2'b11
    } pin_mode_t;
endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pin_q
);
    logic [WIDTH-1:0] hold_lat;

    // transparent while clk is high, holds during the low phase
    always_latch begin
        if (clk) begin
            hold_lat = pad_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= hold_lat;
        end
    end
endmodule

// File: rtl/gpio_reg_file.sv
`timescale 1ns/1ps
module gpio_reg_file
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_t         sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DATA: data_q <= wr_data;
                SEL_DIR:  dir_q  <= wr_data;
                SEL_PIN:  data_q <= data_q ^ wr_data;
                SEL_NONE: ;
            endcase
        end
    end

    AST_TOGGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_PIN) |=> (data_q == ($past(data_q) ^ $past(wr_data)))); // R6
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_DIR) |=> $stable(dir_q)); // R2
    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> ($stable(dir_q) && $stable(data_q))); // R10
endmodule

// File: rtl/gpio_pad_ctrl.sv
`timescale 1ns/1ps
module gpio_pad_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] data_q,
    input  logic             pu_off,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pin_mode_t mode;
        assign mode = pin_mode_t'({dir_q[i], data_q[i]});

        always_comb begin
            pad_oe[i]  = 1'b0;
            pad_out[i] = 1'b0;
            pad_pu[i]  = 1'b0;
            unique case (mode)
                MODE_FLOAT:    ;
                MODE_PULL:     pad_pu[i] = !pu_off;
                MODE_DRIVE_LO: pad_oe[i] = 1'b1;
                MODE_DRIVE_HI: begin
                    pad_oe[i]  = 1'b1;
                    pad_out[i] = 1'b1;
                end
            endcase
        end
    end

    AST_PULL_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pu_off |-> (pad_pu == '0)); // R5
    AST_OE_PU_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_pu) == '0)); // R4
endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    input  logic             pu_off,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    reg_sel_t         sel;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] pin_q;

    assign sel = reg_sel_t'(addr);

    gpio_reg_file #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .dir_q   (dir_q),
        .data_q  (data_q)
    );

    gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pads (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_q   (dir_q),
        .data_q  (data_q),
        .pu_off  (pu_off),
        .pad_oe  (pad_oe),
        .pad_out (pad_out),
        .pad_pu  (pad_pu)
    );

    gpio_pin_sync #(.WIDTH(WIDTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .pin_q  (pin_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            unique case (sel)
                SEL_DATA: rd_data <= data_q;
                SEL_DIR:  rd_data <= dir_q;
                SEL_PIN:  rd_data <= pin_q;
                SEL_NONE: rd_data <= '0;
            endcase
        end
    end

    AST_DRIVE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ data_q) & pad_oe) == '0)); // R3
endmodule

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         pu_off = 1'b0;
    logic [W-1:0] pad;
    logic [W-1:0] pad_oe, pad_out, pad_pu;
    logic [W-1:0] ext_en = '0;
    logic [W-1:0] ext_val = '0;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk; // 125 MHz

    // Pad model: the DUT driver wins, then the external driver, then the weak pull-up.
    // A pin that nothing drives or pulls reads 0.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (pad_oe[i])       pad[i] = pad_out[i];
            else if (ext_en[i])  pad[i] = ext_val[i];
            else                 pad[i] = pad_pu[i];
        end
    end

    gpio_port_ctrl #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pu_off(pu_off), .pad_in(pad),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        @(posedge clk); #2;
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
        @(posedge clk); #2;
        addr = a; wr_en = 1'b0;
        @(posedge clk); #2;
        d = rd_data;
    endtask

    task automatic t_reset();
        chk("R1 dir_oe", pad_oe, 8'h00);
        chk("R1 pu", pad_pu, 8'h00);
        chk("R1 rd", rd_data, 8'h00);
    endtask

    task automatic t_regs_rw();
        logic [W-1:0] v;
        bus_write(2'd1, 8'h5A);
        bus_write(2'd0, 8'hC3);
        bus_read(2'd1, v); chk("R2 dir readback", v, 8'h5A);
        bus_read(2'd0, v); chk("R2 data readback", v, 8'hC3);
    endtask

    task automatic t_drive();
        bus_write(2'd1, 8'hF0);
        bus_write(2'd0, 8'h3C);
        chk("R3 oe", pad_oe, 8'hF0);
        chk("R3 out", pad_out & pad_oe, 8'h30);
        chk("R4 pu mixed", pad_pu, 8'h0C);
    endtask

    task automatic t_pullup();
        logic [W-1:0] v;
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h0F);
        chk("R4 pu", pad_pu, 8'h0F);
        bus_read(2'd2, v); chk("R4 pulled pins read", v, 8'h0F);
    endtask

    task automatic t_pull_disable();
        logic [W-1:0] v;
        @(posedge clk); #2; pu_off = 1'b1;
        #1; chk("R5 pu forced off", pad_pu, 8'h00);
        bus_read(2'd2, v); bus_read(2'd2, v);
        chk("R5 pins float low", v, 8'h00);
        @(posedge clk); #2; pu_off = 1'b0;
        #1; chk("R5 pu restored", pad_pu, 8'h0F);
    endtask

    task automatic t_toggle();
        logic [W-1:0] v;
        bus_write(2'd1, 8'h81);
        bus_write(2'd0, 8'h96);
        bus_write(2'd2, 8'hF0);
        bus_read(2'd0, v); chk("R6 toggle mixed dir", v, 8'h66);
        bus_write(2'd2, 8'h00);
        bus_read(2'd0, v); chk("R6 zero write holds", v, 8'h66);
    endtask

    task automatic t_pin_nowrite();
        logic [W-1:0] v;
        bus_write(2'd1, 8'h00);
        @(posedge clk); #2; ext_en = 8'hFF; ext_val = 8'h3A;
        bus_write(2'd2, 8'hFF);
        bus_read(2'd2, v); chk("R7 pin not written", v, 8'h3A);
        bus_read(2'd0, v); chk("R7 data toggled", v, 8'h99);
    endtask

    task automatic t_sync_delay();
        // address 2 is held; the pad changes 2 ns after edge E0 (clock high)
        @(posedge clk); #2; addr = 2'd2; ext_val = 8'h3A;
        @(posedge clk); #2;
        @(posedge clk); #2;
        ext_val = 8'hC5;              // E0 + 2 ns
        @(posedge clk); #2;           // E1: read holds old level
        chk("R8 not yet visible", rd_data, 8'h3A);
        @(posedge clk); #2;           // E2: new level visible
        chk("R8 visible", rd_data, 8'hC5);
        ext_en = 8'h00;
    endtask

    task automatic t_loopback();
        logic [W-1:0] v;
        bus_write(2'd1, 8'hFF);
        bus_write(2'd0, 8'hA5);
        @(posedge clk);
        bus_read(2'd2, v); chk("R9 output loopback", v, 8'hA5);
    endtask

    task automatic t_unmapped();
        logic [W-1:0] v;
        bus_write(2'd3, 8'h0F);
        bus_read(2'd3, v); chk("R10 read zero", v, 8'h00);
        bus_read(2'd1, v); chk("R10 dir untouched", v, 8'hFF);
        bus_read(2'd0, v); chk("R10 data untouched", v, 8'hA5);
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        t_regs_rw();
        t_drive();
        t_pullup();
        t_pull_disable();
        t_toggle();
        t_pin_nowrite();
        t_sync_delay();
        t_loopback();
        t_unmapped();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule